// File: doc/BRIEF.md
# Shadow-Stack Pointer Register with Privilege Gating

This block keeps the shadow-stack pointer as a control register at CSR address 0x011. It takes CSR read and write requests, checks them against the current privilege mode and a chain of three shadow-stack enable bits (machine, hypervisor and supervisor level), and returns read data, an illegal-instruction fault or a virtual-instruction fault. One cycle after an access, every response appears on registered outputs.

The visible width of the pointer follows the current XLEN, which is 32 or 64. The low bits that can never hold part of an aligned shadow-stack address read as zero. The block also decides whether the atomic shadow-stack swap instruction faults in the current mode. That decision uses its own request strobe and its own pair of registered fault outputs. Instruction decode, trap delivery and memory access are handled elsewhere.

Top module: `sspc_top`

## Requirements
- R1: After a synchronous reset, the outputs `resp_valid`, `flt_illegal`, `flt_virtual`, `swp_illegal`, `swp_virtual` and `rd_data` are 0, and the stored pointer reads as 0.
- R2: An access is taken only when `req_valid` is 1 and `req_addr` equals 12'h011. Any other address gives no response (`resp_valid` stays 0) and leaves the stored pointer unchanged.
- R3: With `xlen64`=1, bits 2:0 of the returned pointer read as 0. With `xlen64`=0, bits 1:0 read as 0. Each mask applies both when the value is stored and when it is read, and uses the XLEN that is current at that access.
- R4: With `xlen64`=0, bits 63:32 of `rd_data` are 0, and a write stores only bits 31:0 of `req_wdata`.
- R5: Accesses in M-mode (`priv`=3'd3) never raise a fault, whatever the enable bits are.
- R6: Privilege codes are U=3'd0, S=3'd1, M=3'd3, VU=3'd4, VS=3'd5. Any other code raises an illegal-instruction fault. An access from any mode other than M while `en_m`=0 raises `flt_illegal`.
- R7: An access from U-mode while `en_s`=0 raises `flt_illegal`.
- R8: If no illegal-instruction condition applies, an access raises `flt_virtual` from VS-mode when `en_h`=0, and from VU-mode when `en_h`=0 or `en_s`=0.
- R9: At most one of `flt_illegal` and `flt_virtual` is 1. Each is 1 only together with `resp_valid`, and a faulting response returns `rd_data`=0.
- R10: A faulting write leaves the stored pointer unchanged. A successful write stores the masked write data.
- R11: The response comes one cycle after the request. `rd_data` carries the masked value the pointer held before the access, so a write returns the old value.
- R12: For a swap check (`swp_valid`=1), the result comes one cycle later. M-mode never faults. With `en_m`=0, every other mode raises `swp_illegal`. With `en_m`=1: VS with `en_h`=0 raises `swp_virtual`, U with `en_s`=0 raises `swp_illegal`, VU with `en_s`=0 raises `swp_virtual`, and S never faults. At most one of the two outputs is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CSR access strobe |
| req_addr | input | 12 | CSR address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| priv | input | 3 | Current privilege mode code |
| en_m | input | 1 | Machine-level shadow-stack enable |
| en_h | input | 1 | Hypervisor-level shadow-stack enable |
| en_s | input | 1 | Supervisor-level shadow-stack enable |
| xlen64 | input | 1 | 1 = XLEN 64, 0 = XLEN 32 |
| swp_valid | input | 1 | Swap-instruction fault check strobe |
| resp_valid | output | 1 | Access response valid |
| rd_data | output | 64 | Old pointer value, masked |
| flt_illegal | output | 1 | Access raises an illegal-instruction fault |
| flt_virtual | output | 1 | Access raises a virtual-instruction fault |
| swp_illegal | output | 1 | Swap raises an illegal-instruction fault |
| swp_virtual | output | 1 | Swap raises a virtual-instruction fault |

## Verification
The hardest case to reach is a pointer written under one XLEN and read under the other. Bit 2 survives a 32-bit write but must disappear from a 64-bit read, and the upper half written in 64-bit mode must be hidden from a 32-bit read. The bench writes from M-mode with a pattern that sets every low bit, changes `xlen64`, and reads the pointer back in the other width. It also writes from faulting modes and reads back from M-mode, so a write that should have been blocked would show at the ports.

// File: rtl/sspc_pkg.sv
package sspc_pkg;
  localparam int XMAX = 64;
  localparam int XMIN = 32;
  localparam logic [11:0] SSP_ADDR = 12'h011;

  typedef enum logic [2:0] {
    PRV_U  = 3'd0,
    PRV_S  = 3'd1,
    PRV_M  = 3'd3,
    PRV_VU = 3'd4,
    PRV_VS = 3'd5
  } prv_e;

  function automatic logic [XMAX-1:0] ptr_mask(input logic wide);
    logic [XMAX-1:0] m;
    if (wide) m = {{(XMAX-3){1'b1}}, 3'b000};
    else      m = {{(XMAX-XMIN){1'b0}}, {(XMIN-2){1'b1}}, 2'b00};
    return m;
  endfunction
endpackage

// File: rtl/sspc_perm.sv
module sspc_perm
  import sspc_pkg::*;
(
  input  logic [2:0] priv,
  input  logic       en_m,
  input  logic       en_h,
  input  logic       en_s,
  output logic       acc_ill,
  output logic       acc_virt,
  output logic       swp_ill,
  output logic       swp_virt
);
  logic is_u, is_s, is_m, is_vu, is_vs, bad_code, below_m;

  always_comb begin
    is_u     = (priv == PRV_U);
    is_s     = (priv == PRV_S);
    is_m     = (priv == PRV_M);
    is_vu    = (priv == PRV_VU);
    is_vs    = (priv == PRV_VS);
    bad_code = !(is_u || is_s || is_m || is_vu || is_vs);
    below_m  = !is_m;

    // access to the pointer register: illegal checks take priority
    acc_ill  = bad_code || (below_m && !en_m) || (is_u && !en_s);
    acc_virt = !acc_ill && ((is_vs && !en_h) || (is_vu && (!en_h || !en_s)));

    // atomic swap instruction
    swp_ill  = bad_code || (below_m && !en_m) || (is_u && !en_s);
    swp_virt = !swp_ill && ((is_vs && !en_h) || (is_vu && !en_s));
  end
endmodule

// File: rtl/sspc_store.sv
module sspc_store
  import sspc_pkg::*;
#(
  parameter int W = XMAX
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         xlen64,
  output logic [W-1:0] ptr_q,
  output logic [W-1:0] view
);
  logic [W-1:0] mask;

  always_comb begin
    mask = ptr_mask(xlen64);
    view = ptr_q & mask;
  end

  always_ff @(posedge clk) begin
    if (rst)     ptr_q <= '0;
    else if (we) ptr_q <= wdata & mask;
  end
endmodule

// File: rtl/sspc_top.sv
module sspc_top
  import sspc_pkg::*;
#(
  parameter int          W    = XMAX,
  parameter int          AW   = 12,
  parameter logic [11:0] ADDR = SSP_ADDR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [W-1:0]  req_wdata,
  input  logic [2:0]    priv,
  input  logic          en_m,
  input  logic          en_h,
  input  logic          en_s,
  input  logic          xlen64,
  input  logic          swp_valid,
  output logic          resp_valid,
  output logic [W-1:0]  rd_data,
  output logic          flt_illegal,
  output logic          flt_virtual,
  output logic          swp_illegal,
  output logic          swp_virtual
);
  logic acc_ill, acc_virt, s_ill, s_virt;
  logic hit, ok, we;
  logic [W-1:0] ptr_q, view;

  sspc_perm u_perm (
    .priv(priv), .en_m(en_m), .en_h(en_h), .en_s(en_s),
    .acc_ill(acc_ill), .acc_virt(acc_virt),
    .swp_ill(s_ill), .swp_virt(s_virt)
  );

  always_comb begin
    hit = req_valid && (req_addr == ADDR[AW-1:0]);
    ok  = hit && !acc_ill && !acc_virt;
    we  = ok && req_write;
  end

  sspc_store #(.W(W)) u_store (
    .clk(clk), .rst(rst), .we(we), .wdata(req_wdata),
    .xlen64(xlen64), .ptr_q(ptr_q), .view(view)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      rd_data     <= '0;
      flt_illegal <= 1'b0;
      flt_virtual <= 1'b0;
      swp_illegal <= 1'b0;
      swp_virtual <= 1'b0;
    end else begin
      resp_valid  <= hit;
      rd_data     <= ok ? view : '0;
      flt_illegal <= hit && acc_ill;
      flt_virtual <= hit && acc_virt;
      swp_illegal <= swp_valid && s_ill;
      swp_virtual <= swp_valid && s_virt;
    end
  end
endmodule

// File: rtl/sspc_chk.sv
module sspc_chk
  import sspc_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [11:0]   req_addr,
  input logic [2:0]    priv,
  input logic          swp_valid,
  input logic          resp_valid,
  input logic [63:0]   rd_data,
  input logic          flt_illegal,
  input logic          flt_virtual,
  input logic          swp_illegal,
  input logic          swp_virtual,
  input logic [63:0]   ptr_q
);
  // R9
  one_fault_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flt_illegal, flt_virtual}));

  // R9
  fault_has_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_illegal || flt_virtual) |-> (resp_valid && rd_data == '0));

  // R2
  resp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_addr == SSP_ADDR) |=> !resp_valid);

  // R11
  resp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr == SSP_ADDR) |=> resp_valid);

  // R5
  mmode_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && priv == PRV_M) |=> (!flt_illegal && !flt_virtual));

  // R3
  low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[1:0] == 2'b00);

  // R10
  fault_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_illegal || flt_virtual) |-> (ptr_q == $past(ptr_q)));

  // R12
  swap_one_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({swp_illegal, swp_virtual}));

  // R12
  swap_m_chk: assert property (@(posedge clk) disable iff (rst)
    (swp_valid && priv == PRV_M) |=> (!swp_illegal && !swp_virtual));
endmodule

bind sspc_top sspc_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .priv(priv), .swp_valid(swp_valid), .resp_valid(resp_valid),
  .rd_data(rd_data), .flt_illegal(flt_illegal), .flt_virtual(flt_virtual),
  .swp_illegal(swp_illegal), .swp_virtual(swp_virtual), .ptr_q(ptr_q)
);

// File: tb/sspc_top_tb.sv
module sspc_top_tb;
  localparam logic [2:0] U = 3'd0, S = 3'd1, M = 3'd3, VU = 3'd4, VS = 3'd5;
  localparam logic [11:0] A = 12'h011;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, en_m = 0, en_h = 0, en_s = 0;
  logic xlen64 = 1, swp_valid = 0;
  logic [11:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic [2:0] priv = M;
  logic resp_valid, flt_illegal, flt_virtual, swp_illegal, swp_virtual;
  logic [63:0] rd_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sspc_top u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .priv(priv),
    .en_m(en_m), .en_h(en_h), .en_s(en_s), .xlen64(xlen64),
    .swp_valid(swp_valid), .resp_valid(resp_valid), .rd_data(rd_data),
    .flt_illegal(flt_illegal), .flt_virtual(flt_virtual),
    .swp_illegal(swp_illegal), .swp_virtual(swp_virtual)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one access at a falling edge, look at the result one edge later
  task automatic acc(input logic wr, input logic [11:0] ad, input logic [63:0] d,
                     input logic [2:0] p);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = ad; req_wdata = d; priv = p;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic set_en(input logic m, input logic h, input logic s);
    en_m = m; en_h = h; en_s = s;
  endtask

  task automatic expect_acc(input string tag, input logic v, input logic ill,
                            input logic vir, input logic [63:0] d);
    chk({tag, " resp_valid"}, {63'd0, resp_valid}, {63'd0, v});
    chk({tag, " illegal"}, {63'd0, flt_illegal}, {63'd0, ill});
    chk({tag, " virtual"}, {63'd0, flt_virtual}, {63'd0, vir});
    chk({tag, " data"}, rd_data, d);
  endtask

  task automatic swap(input string tag, input logic [2:0] p, input logic ill,
                      input logic vir);
    @(negedge clk);
    swp_valid = 1; priv = p;
    @(negedge clk);
    swp_valid = 0;
    chk({tag, " swp_illegal"}, {63'd0, swp_illegal}, {63'd0, ill});
    chk({tag, " swp_virtual"}, {63'd0, swp_virtual}, {63'd0, vir});
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    rst = 0;
    expect_acc("R1 reset outputs", 0, 0, 0, 64'd0);
    chk("R1 swap outputs", {62'd0, swp_illegal, swp_virtual}, 64'd0);
    acc(0, A, 0, M);
    expect_acc("R1 pointer zero", 1, 0, 0, 64'd0);
  endtask

  task automatic t_write_read;
    xlen64 = 1;
    acc(1, A, 64'hFFFF_FFFF_FFFF_FFFF, M);
    expect_acc("R11 write returns old", 1, 0, 0, 64'd0);
    acc(0, A, 0, M);
    expect_acc("R3 read 64 masked", 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFF8);
    xlen64 = 0;
    acc(0, A, 0, M);
    expect_acc("R4 read under 32", 1, 0, 0, 64'h0000_0000_FFFF_FFF8);
    acc(1, A, 64'h1234_5678_9ABC_DEF7, M);
    expect_acc("R11 old value on write", 1, 0, 0, 64'h0000_0000_FFFF_FFF8);
    acc(0, A, 0, M);
    expect_acc("R4 R3 stored 32", 1, 0, 0, 64'h0000_0000_9ABC_DEF4);
    xlen64 = 1;
    acc(0, A, 0, M);
    expect_acc("R3 bit2 hidden 64", 1, 0, 0, 64'h0000_0000_9ABC_DEF0);
  endtask

  task automatic t_addr;
    acc(1, 12'h012, 64'hAAAA_0000_0000_0008, M);
    expect_acc("R2 other address", 0, 0, 0, 64'd0);
    acc(1, 12'h111, 64'hAAAA_0000_0000_0008, U);
    expect_acc("R2 other address U", 0, 0, 0, 64'd0);
    acc(0, A, 0, M);
    expect_acc("R2 pointer kept", 1, 0, 0, 64'h0000_0000_9ABC_DEF0);
  endtask

  task automatic t_mmode;
    set_en(0, 0, 0);
    acc(1, A, 64'h0000_0000_0000_1000, M);
    expect_acc("R5 M with all off", 1, 0, 0, 64'h0000_0000_9ABC_DEF0);
    acc(0, A, 0, M);
    expect_acc("R5 M write stored", 1, 0, 0, 64'h0000_0000_0000_1000);
  endtask

  task automatic t_illegal;
    set_en(0, 1, 1);
    acc(1, A, 64'h55, S);
    expect_acc("R6 S m off", 1, 1, 0, 64'd0);
    acc(1, A, 64'h55, VS);
    expect_acc("R6 VS m off", 1, 1, 0, 64'd0);
    acc(0, A, 0, VU);
    expect_acc("R6 VU m off", 1, 1, 0, 64'd0);
    set_en(1, 1, 1);
    acc(0, A, 0, 3'd2);
    expect_acc("R6 unknown code", 1, 1, 0, 64'd0);
    set_en(1, 0, 0);
    acc(1, A, 64'h77, U);
    expect_acc("R7 U s off", 1, 1, 0, 64'd0);
    acc(0, A, 0, S);
    expect_acc("R6 S ok with m on", 1, 0, 0, 64'h1000);
  endtask

  task automatic t_virtual;
    set_en(1, 0, 1);
    acc(1, A, 64'h99, VS);
    expect_acc("R8 VS h off", 1, 0, 1, 64'd0);
    acc(1, A, 64'h99, VU);
    expect_acc("R8 VU h off", 1, 0, 1, 64'd0);
    set_en(1, 1, 0);
    acc(0, A, 0, VU);
    expect_acc("R8 VU s off", 1, 0, 1, 64'd0);
    acc(0, A, 0, VS);
    expect_acc("R8 VS ok", 1, 0, 0, 64'h1000);
    set_en(0, 0, 0);
    acc(0, A, 0, VS);
    expect_acc("R9 illegal wins", 1, 1, 0, 64'd0);
  endtask

  task automatic t_fault_write;
    acc(0, A, 0, M);
    expect_acc("R10 pointer unchanged", 1, 0, 0, 64'h1000);
    set_en(1, 1, 1);
    acc(1, A, 64'h0000_0001_0000_002F, VU);
    expect_acc("R10 VU ok write", 1, 0, 0, 64'h1000);
    acc(0, A, 0, U);
    expect_acc("R10 stored masked", 1, 0, 0, 64'h0000_0001_0000_0028);
  endtask

  task automatic t_swap;
    set_en(0, 1, 1);
    swap("R12 M m off", M, 0, 0);
    swap("R12 S m off", S, 1, 0);
    swap("R12 VU m off", VU, 1, 0);
    set_en(1, 0, 1);
    swap("R12 VS h off", VS, 0, 1);
    swap("R12 VU h off s on", VU, 0, 0);
    set_en(1, 1, 0);
    swap("R12 U s off", U, 1, 0);
    swap("R12 VU s off", VU, 0, 1);
    swap("R12 S m on", S, 0, 0);
    set_en(1, 1, 1);
    swap("R12 U all on", U, 0, 0);
  endtask

  initial begin
    t_reset;
    t_write_read;
    t_addr;
    t_mmode;
    t_illegal;
    t_virtual;
    t_fault_write;
    t_swap;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule